// File: doc/BRIEF.md
# Latency-Matched Complex Butterfly

A pipelined radix-2 butterfly for one stage of a streaming FFT. Each enabled clock it accepts two complex samples `a` and `b`, a complex twiddle `w` and a marker flag. It returns `a + b` on the sum port and `(a - b) * w` on the difference port. The complex product uses three real multiplications that are then recombined into the real and imaginary parts. The product is scaled back by the twiddle's fixed-point weight and truncated to the output width.

A parameter selects the multiplier build. The shift-and-add build is a bit-serial array that is pipelined, so it still accepts one operand pair per clock. It costs one register stage per bit of the data operand. The native build uses the `*` operator with a single register. The marker flag runs through a delay line as long as the full pipeline. It therefore leaves the block on the same clock as the results of the pair it came with. The sum path is delayed by the same amount. All stages advance only while the clock enable is high.

Twiddle components are signed integers of width C = IW + CXTRA. They are scaled so that 1.0 is 2^(C-2), which leaves headroom for the recombination sums.

Top module: `bfly_core`

## Requirements
- R1: `sum_re_o`/`sum_im_o` equal `a + b` per component, sign-extended to OW = IW+1 bits, so no overflow occurs.
- R2: With d = a - b, `dif_re_o` = floor((d_re*w_re - d_im*w_im) / 2^(C-2)) and `dif_im_o` = floor((d_re*w_im + d_im*w_re) / 2^(C-2)), each kept as its low OW bits in two's complement.
- R3: Results of a pair captured on an enabled edge appear on the outputs after the LAT-th enabled edge, counting the capture edge. LAT = IW+4 in shift-and-add mode (MUL_KIND = MUL_SHIFT_ADD) and LAT = 3 in native mode (MUL_KIND = MUL_NATIVE).
- R4: `sync_o` is high exactly while the outputs hold the results of a pair captured with `sync_i` high. It is low while the outputs hold the results of any other pair.
- R5: While `en_i` is low, all inputs are ignored, including `sync_i`, and every output holds its value.
- R6: Reset drives all outputs to zero and clears the marker line. `sync_o` stays low until the first marked pair has crossed the pipeline.
- R7: Both multiplier modes produce identical sum and difference values for the same inputs.
- R8: A unity twiddle (`w_re` = 2^(C-2), `w_im` = 0) returns the difference `a - b` unchanged on the difference port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; pipeline advances when high |
| sync_i | input | 1 | Marker for the pair presented this cycle |
| a_re_i | input | IW | Sample a, real part, signed |
| a_im_i | input | IW | Sample a, imaginary part, signed |
| b_re_i | input | IW | Sample b, real part, signed |
| b_im_i | input | IW | Sample b, imaginary part, signed |
| w_re_i | input | IW+CXTRA | Twiddle, real part, signed, 1.0 = 2^(C-2) |
| w_im_i | input | IW+CXTRA | Twiddle, imaginary part, signed |
| sync_o | output | 1 | Marker aligned with the outputs |
| sum_re_o | output | IW+1 | Real part of a + b |
| sum_im_o | output | IW+1 | Imaginary part of a + b |
| dif_re_o | output | IW+1 | Real part of (a - b) * w |
| dif_im_o | output | IW+1 | Imaginary part of (a - b) * w |

## Verification
The case that needs care is a marker arriving together with a stall. The bench raises `sync_i` on cycles where `en_i` is low. It also places marked pairs directly before and after stalls, so that the marker line and the hold behaviour act on the same cycle. Judging relies on a scoreboard that counts only enabled edges. An output must carry its marker on the edge where its data is due. Across held cycles, both the marker and the data must stay frozen. Any `sync_o` pulse caused by a marker that was offered during a stall shows up as a marker mismatch.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  typedef enum logic {
    MUL_SHIFT_ADD = 1'b0,
    MUL_NATIVE    = 1'b1
  } mul_kind_e;

  function automatic int unsigned mul_latency(mul_kind_e kind, int unsigned aw);
    return (kind == MUL_NATIVE) ? 1 : aw;
  endfunction

endpackage

// File: rtl/bfly_dly.sv
module bfly_dly #(
  parameter int unsigned W = 1,
  parameter int unsigned D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sr_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < D; k++) sr_q[k] <= '0;
    end else if (en_i) begin
      sr_q[0] <= d_i;
      for (int k = 1; k < D; k++) sr_q[k] <= sr_q[k-1];
    end
  end

  assign q_o = sr_q[D-1];

endmodule

// File: rtl/bfly_mul.sv
module bfly_mul
  import bfly_pkg::*;
#(
  parameter int unsigned AW   = 10,
  parameter int unsigned BW   = 13,
  parameter mul_kind_e   KIND = MUL_SHIFT_ADD,
  localparam int unsigned PW  = AW + BW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [AW-1:0] a_i,
  input  logic signed [BW-1:0] b_i,
  output logic signed [PW-1:0] p_o
);

  logic signed [PW-1:0] bx;
  assign bx = PW'(b_i);

  if (KIND == MUL_NATIVE) begin : g_native
    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] p_q;
    assign ax = PW'(a_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   p_q <= '0;
      else if (en_i) p_q <= ax * bx;
    end
    assign p_o = p_q;

  end else begin : g_shift_add
    // one stage per data bit; sign bit carries negative weight
    logic signed [PW-1:0] acc_q [AW];
    logic        [AW-1:0] a_q   [AW-1];
    logic signed [PW-1:0] b_q   [AW-1];

    function automatic logic signed [PW-1:0] step(
      input logic signed [PW-1:0] acc,
      input logic        [AW-1:0] a,
      input logic signed [PW-1:0] b,
      input int unsigned          k
    );
      logic signed [PW-1:0] sh;
      sh = b <<< k;
      if (!a[k]) return acc;
      return (k == AW - 1) ? acc - sh : acc + sh;
    endfunction

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < AW; k++) acc_q[k] <= '0;
        for (int k = 0; k < AW - 1; k++) begin
          a_q[k] <= '0;
          b_q[k] <= '0;
        end
      end else if (en_i) begin
        acc_q[0] <= step('0, a_i, bx, 0);
        a_q[0]   <= a_i;
        b_q[0]   <= bx;
        for (int k = 1; k < AW; k++) begin
          acc_q[k] <= step(acc_q[k-1], a_q[k-1], b_q[k-1], k);
        end
        for (int k = 1; k < AW - 1; k++) begin
          a_q[k] <= a_q[k-1];
          b_q[k] <= b_q[k-1];
        end
      end
    end
    assign p_o = acc_q[AW-1];
  end

endmodule

// File: rtl/bfly_core.sv
module bfly_core
  import bfly_pkg::*;
#(
  parameter int unsigned IW       = 8,
  parameter int unsigned CXTRA    = 4,
  parameter mul_kind_e   MUL_KIND = MUL_SHIFT_ADD,
  localparam int unsigned CW      = IW + CXTRA,
  localparam int unsigned OW      = IW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 sync_i,
  input  logic signed [IW-1:0] a_re_i,
  input  logic signed [IW-1:0] a_im_i,
  input  logic signed [IW-1:0] b_re_i,
  input  logic signed [IW-1:0] b_im_i,
  input  logic signed [CW-1:0] w_re_i,
  input  logic signed [CW-1:0] w_im_i,
  output logic                 sync_o,
  output logic signed [OW-1:0] sum_re_o,
  output logic signed [OW-1:0] sum_im_o,
  output logic signed [OW-1:0] dif_re_o,
  output logic signed [OW-1:0] dif_im_o
);

  localparam int unsigned DA      = OW + 1;
  localparam int unsigned CA      = CW + 1;
  localparam int unsigned PW      = DA + CA;
  localparam int unsigned MUL_LAT = mul_latency(MUL_KIND, DA);
  localparam int unsigned LAT     = MUL_LAT + 2;
  localparam int unsigned SHIFT   = CW - 2;

  // stage 0: add/subtract and operand forming
  logic signed [OW-1:0] s_re, s_im, d_re, d_im;
  assign s_re = OW'(a_re_i) + OW'(b_re_i);
  assign s_im = OW'(a_im_i) + OW'(b_im_i);
  assign d_re = OW'(a_re_i) - OW'(b_re_i);
  assign d_im = OW'(a_im_i) - OW'(b_im_i);

  logic signed [DA-1:0] x_q [3];
  logic signed [CA-1:0] c_q [3];
  logic        [2*OW-1:0] s_q;

  // m0 = wr*(dr+di), m1 = di*(wr+wi), m2 = dr*(wi-wr)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 3; k++) begin
        x_q[k] <= '0;
        c_q[k] <= '0;
      end
      s_q <= '0;
    end else if (en_i) begin
      x_q[0] <= DA'(d_re) + DA'(d_im);
      c_q[0] <= CA'(w_re_i);
      x_q[1] <= DA'(d_im);
      c_q[1] <= CA'(w_re_i) + CA'(w_im_i);
      x_q[2] <= DA'(d_re);
      c_q[2] <= CA'(w_im_i) - CA'(w_re_i);
      s_q    <= {s_re, s_im};
    end
  end

  logic signed [PW-1:0] m [3];

  for (genvar g = 0; g < 3; g++) begin : g_mul
    bfly_mul #(
      .AW   (DA),
      .BW   (CA),
      .KIND (MUL_KIND)
    ) u_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .a_i    (x_q[g]),
      .b_i    (c_q[g]),
      .p_o    (m[g])
    );
  end

  logic [2*OW-1:0] s_dly;

  bfly_dly #(
    .W (2 * OW),
    .D (MUL_LAT)
  ) u_sum_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .d_i    (s_q),
    .q_o    (s_dly)
  );

  bfly_dly #(
    .W (1),
    .D (LAT)
  ) u_sync_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .d_i    (sync_i),
    .q_o    (sync_o)
  );

  // recombine, drop coefficient scale, wrap to OW
  logic signed [PW:0]   prod_re, prod_im;
  logic signed [OW-1:0] dif_re_d, dif_im_d;
  assign prod_re  = (PW+1)'(m[0]) - (PW+1)'(m[1]);
  assign prod_im  = (PW+1)'(m[0]) + (PW+1)'(m[2]);
  assign dif_re_d = OW'(prod_re >>> SHIFT);
  assign dif_im_d = OW'(prod_im >>> SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_re_o <= '0;
      sum_im_o <= '0;
      dif_re_o <= '0;
      dif_im_o <= '0;
    end else if (en_i) begin
      {sum_re_o, sum_im_o} <= s_dly;
      dif_re_o <= dif_re_d;
      dif_im_o <= dif_im_d;
    end
  end

endmodule

// File: rtl/bfly_core_chk.sv
module bfly_core_chk #(
  parameter int unsigned LAT = 3,
  parameter int unsigned OW  = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          sync_i,
  input logic          sync_o,
  input logic [OW-1:0] sum_re_o,
  input logic [OW-1:0] sum_im_o,
  input logic [OW-1:0] dif_re_o,
  input logic [OW-1:0] dif_im_o
);

  int unsigned en_cnt_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_cnt_q <= 0;
      seen_q   <= 1'b0;
    end else if (en_i) begin
      if (en_cnt_q < LAT) en_cnt_q <= en_cnt_q + 1;
      if (sync_i) seen_q <= 1'b1;
    end
  end

  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sum_re_o) && $stable(sum_im_o) && $stable(dif_re_o) && $stable(dif_im_o)); // R5

  AST_HOLD_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sync_o)); // R5

  AST_NO_EARLY_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_cnt_q < LAT) |-> !sync_o); // R6

  AST_SYNC_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> seen_q); // R4

endmodule

bind bfly_core bfly_core_chk #(
  .LAT (LAT),
  .OW  (OW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .sync_i   (sync_i),
  .sync_o   (sync_o),
  .sum_re_o (sum_re_o),
  .sum_im_o (sum_im_o),
  .dif_re_o (dif_re_o),
  .dif_im_o (dif_im_o)
);

// File: tb/bfly_core_tb.sv
`timescale 1ns/1ps
module bfly_core_tb;
  import bfly_pkg::*;

  localparam int IW = 8;
  localparam int CX = 4;
  localparam int CW = IW + CX;
  localparam int OW = IW + 1;
  localparam int SH = CW - 2;
  localparam int LAT_SA = IW + 4;
  localparam int LAT_NA = 3;

  typedef struct packed {
    logic [31:0]   due;
    logic          sy;
    logic          unity;
    logic [OW-1:0] sr, si, dr, di;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sync = 1'b0;
  logic signed [IW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic signed [CW-1:0] w_re = '0, w_im = '0;

  logic          sy_sa, sy_na;
  logic [OW-1:0] sr_sa, si_sa, dr_sa, di_sa;
  logic [OW-1:0] sr_na, si_na, dr_na, di_na;

  always #10 clk = ~clk;

  bfly_core #(.IW(IW), .CXTRA(CX), .MUL_KIND(MUL_SHIFT_ADD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sync_i(sync),
    .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im),
    .w_re_i(w_re), .w_im_i(w_im), .sync_o(sy_sa),
    .sum_re_o(sr_sa), .sum_im_o(si_sa), .dif_re_o(dr_sa), .dif_im_o(di_sa));

  bfly_core #(.IW(IW), .CXTRA(CX), .MUL_KIND(MUL_NATIVE)) u_dut_na (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sync_i(sync),
    .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im),
    .w_re_i(w_re), .w_im_i(w_im), .sync_o(sy_na),
    .sum_re_o(sr_na), .sum_im_o(si_na), .dif_re_o(dr_na), .dif_im_o(di_na));

  int nchk = 0, nfail = 0;
  bit done = 0, mon_on = 0;
  int unsigned ecnt = 0;
  exp_t q_sa[$], q_na[$];

  always @(posedge clk) if (rst_n && en) ecnt <= ecnt + 1;

  task automatic cmp(string tag, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(bit e, bit sy, int ar, int ai, int br, int bi, int wr, int wi);
    exp_t it;
    int dre, dim, pre, pim;
    @(negedge clk);
    en = e; sync = sy;
    a_re = IW'(ar); a_im = IW'(ai); b_re = IW'(br); b_im = IW'(bi);
    w_re = CW'(wr); w_im = CW'(wi);
    if (e) begin
      dre = ar - br; dim = ai - bi;
      pre = dre * wr - dim * wi;
      pim = dre * wi + dim * wr;
      it.sy = sy;
      it.unity = (wr == (1 << SH)) && (wi == 0);
      it.sr = OW'(ar + br); it.si = OW'(ai + bi);
      it.dr = OW'(pre >>> SH); it.di = OW'(pim >>> SH);
      it.due = ecnt + LAT_SA; q_sa.push_back(it);
      it.due = ecnt + LAT_NA; q_na.push_back(it);
    end
  endtask

  // monitor: shift-and-add instance
  int unsigned last_sa = 0;
  logic [4*OW:0] snap_sa = '0;
  always @(negedge clk) if (mon_on) begin
    exp_t it;
    if (ecnt != last_sa) begin
      last_sa = ecnt;
      if (q_sa.size() > 0 && q_sa[0].due == ecnt) begin
        it = q_sa.pop_front();
        cmp("R3/R4", "sa sync", sy_sa, it.sy);
        cmp("R1", "sa sum_re", sr_sa, it.sr);
        cmp("R1", "sa sum_im", si_sa, it.si);
        cmp(it.unity ? "R8" : "R2", "sa dif_re", dr_sa, it.dr);
        cmp(it.unity ? "R8" : "R2", "sa dif_im", di_sa, it.di);
      end else cmp("R6", "sa sync during fill", sy_sa, 0);
    end else cmp("R5", "sa hold", {sy_sa, sr_sa, si_sa, dr_sa, di_sa}, snap_sa);
    snap_sa = {sy_sa, sr_sa, si_sa, dr_sa, di_sa};
  end

  // monitor: native instance
  int unsigned last_na = 0;
  logic [4*OW:0] snap_na = '0;
  always @(negedge clk) if (mon_on) begin
    exp_t it;
    if (ecnt != last_na) begin
      last_na = ecnt;
      if (q_na.size() > 0 && q_na[0].due == ecnt) begin
        it = q_na.pop_front();
        cmp("R3/R4", "na sync", sy_na, it.sy);
        cmp("R1/R7", "na sum_re", sr_na, it.sr);
        cmp("R1/R7", "na sum_im", si_na, it.si);
        cmp(it.unity ? "R8" : "R7", "na dif_re", dr_na, it.dr);
        cmp(it.unity ? "R8" : "R7", "na dif_im", di_na, it.di);
      end else cmp("R6", "na sync during fill", sy_na, 0);
    end else cmp("R5", "na hold", {sy_na, sr_na, si_na, dr_na, di_na}, snap_na);
    snap_na = {sy_na, sr_na, si_na, dr_na, di_na};
  end

  function automatic int tw_cos(int n);
    return $rtoi($floor((2.0 ** SH) * $cos(2.0 * 3.14159265358979 * n / 16.0) + 0.5));
  endfunction
  function automatic int tw_sin(int n);
    return $rtoi($floor((2.0 ** SH) * $sin(2.0 * 3.14159265358979 * n / 16.0) + 0.5));
  endfunction

  function automatic int rs(int w);
    return int'($urandom_range(0, (1 << w) - 1)) - (1 << (w - 1));
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    cmp("R6", "sa reset", {sy_sa, sr_sa, si_sa, dr_sa, di_sa}, 0);
    cmp("R6", "na reset", {sy_na, sr_na, si_na, dr_na, di_na}, 0);
    rst_n = 1'b1;
    mon_on = 1;
    // R8 unity twiddle with marked first pair, plus extremes
    drive(1, 1, 100, -50, -27, 90, 1 << SH, 0);
    drive(1, 0, 127, 127, -128, -128, 1 << SH, 0);
    drive(1, 0, -128, -128, 127, 127, (1 << (CW - 1)) - 1, (1 << (CW - 1)) - 1);
    drive(1, 0, -128, 127, 127, -128, -(1 << (CW - 1)), -(1 << (CW - 1)));
    drive(1, 0, 127, -128, -128, 127, -(1 << (CW - 1)), (1 << (CW - 1)) - 1);
    // R5 marker offered during stall must be ignored
    drive(0, 1, 5, 5, 5, 5, 0, 0);
    drive(0, 1, -9, 3, 4, 4, 7, 7);
    drive(1, 1, 3, 3, 3, 3, 1 << SH, 0);
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    // R2 R7 twiddle table points, random samples
    for (int n = 0; n < 16; n++)
      drive(1, (n % 5) == 0, rs(IW), rs(IW), rs(IW), rs(IW), tw_cos(n), -tw_sin(n));
    // random mix with stalls and markers
    for (int i = 0; i < 400; i++) begin
      if (i % 2 == 0)
        drive($urandom_range(0, 4) != 0, $urandom_range(0, 6) == 0,
              rs(IW), rs(IW), rs(IW), rs(IW), rs(CW), rs(CW));
      else begin
        int n = int'($urandom_range(0, 15));
        drive($urandom_range(0, 4) != 0, $urandom_range(0, 6) == 0,
              rs(IW), rs(IW), rs(IW), rs(IW), tw_cos(n), tw_sin(n));
      end
    end
    // flush
    for (int i = 0; i < LAT_SA + 2; i++) drive(1, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    cmp("R3", "sa pending after flush", q_sa.size() <= LAT_SA, 1);
    cmp("R3", "na pending after flush", q_na.size() <= LAT_NA, 1);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R3 act=timeout exp=finish");
      summary();
      $finish;
    end
  end

endmodule